// File: doc/BRIEF.md
# I2C Interrupt Vector and Status Unit

This unit gathers the event pulses produced by an I2C controller's protocol engine into sticky status flags. It gates them with an interrupt-enable register, drives one interrupt line, and reports the most urgent enabled pending event as a small source code. The block sits behind a simple register port: a 2-bit address, a write strobe, a read strobe, write data, and combinational read data. A read or write takes effect at the clock edge on which its strobe is high.

Seven sources exist. Each source has a code from 1 to 7. Source k occupies bit k-1 in both the enable register and the status register:

| Code | Source | Bit |
|------|--------|-----|
| 1 | arbitration lost | 0 |
| 2 | NACK received | 1 |
| 3 | register access ready | 2 |
| 4 | receive data ready | 3 |
| 5 | transmit ready | 4 |
| 6 | stop detected | 5 |
| 7 | addressed as slave | 6 |

Software reads the vector register repeatedly and services each code until the register reads 0. Reading the vector retires the event it reports, except for the two data-ready sources. Those two are retired by strobes from the data registers, which sit outside this block.

The block has no state machine. Its state is the flag bank and the enable register, and both update on every clock edge from the current strobes.

Register addresses:
- 0: enable register, read/write, bits 6:0.
- 1: status register. Bits 6:0 hold the flags and are write-1-to-clear. Bit 11 shows the live receive-shift-full level and bit 12 shows the live bus-busy level.
- 2: vector register, read only.
- 3: unused.

Top module: `i2c_irq_vector_unit`

## Requirements
- R1: After reset the enable register, all status flags, the vector and `irq` are 0.
- R2: A one-cycle pulse on `evt_i[k-1]` sets status bit k-1 (the bit of source code k) from the next cycle on, whatever the enable register holds. Status bit 12 reads the live `bus_busy_i` level and status bit 11 reads the live `rx_shift_full_i` level.
- R3: A write to address 1 clears each flag whose write-data bit (6:0) is 1 and leaves each flag whose write-data bit is 0 unchanged.
- R4: If an event pulse and any clear condition for the same flag fall in the same cycle, the flag is set after that cycle.
- R5: A write to address 0 loads write-data bits 6:0 into the enable register. Reads of address 0 return the register in bits 6:0 and 0 in all other bits.
- R6: Address 2 reads, in bits 2:0, the lowest code k whose flag and enable bit are both 1. It reads 0 when no such k exists, and all other bits read 0.
- R7: `irq` is 1 exactly when at least one flag is set while its enable bit is also set.
- R8: A read of address 2 clears the flag of the code it returns, for codes 1, 2, 3, 6 and 7. Codes 4 (receive ready) and 5 (transmit ready) are left set.
- R9: A pulse on `rx_data_read_i` clears the receive-ready flag (bit 3). A pulse on `tx_data_write_i` clears the transmit-ready flag (bit 4).
- R10: Writes to address 2 or 3 change no state. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 7 | One-cycle event pulses; bit k-1 belongs to code k |
| bus_busy_i | input | 1 | Live bus-busy level, shown in status bit 12 |
| rx_shift_full_i | input | 1 | Live receive-shift-full level, shown in status bit 11 |
| rx_data_read_i | input | 1 | Strobe: receive data register was read |
| tx_data_write_i | input | 1 | Strobe: transmit data register was written |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (drives side effects) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the current address |
| irq_o | output | 1 | Interrupt line |

## Verification
The encoder is tried with random sets of pending flags under random enable masks. This separates lowest-code priority from highest-code priority, and it separates mask-gated pending from raw pending. Directed sequences drain the vector one read at a time. They show that codes 4 and 5 persist across vector reads while other codes retire, and that the strobes alone retire the two data-ready flags. Same-cycle collisions pit an event pulse against a status write-1-clear, against a vector read and against a data strobe. These collisions distinguish set-priority from clear-priority. Write patterns with mixed 0 and 1 bits show that zeros in a status write leave flags untouched.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
    localparam int NUM_SRC    = 7;
    localparam int CODE_W     = $clog2(NUM_SRC + 1);
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 2;
    localparam int IDX_RXRDY  = 3;
    localparam int IDX_TXRDY  = 4;
    localparam int BIT_RSFULL = 11;
    localparam int BIT_BBUSY  = 12;

    typedef enum logic [ADDR_W-1:0] {
        SEL_ENABLE = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_VECTOR = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_o[g] <= 1'b0;
            else if (set_i[g])
                flag_o[g] <= 1'b1;
            else if (clr_i[g])
                flag_o[g] <= 1'b0;
        end

        // R4: a pulse wins over any simultaneous clear
        p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flag_o[g]);
        // R3: a clear with no pulse drops the flag
        p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !flag_o[g]);
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N  = 7,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  pend_i,
    output logic [CW-1:0] code_o
);
    always_comb begin
        code_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i])
                code_o = CW'(i + 1);
        end
    end
endmodule

// File: rtl/i2c_irq_vector_unit.sv
module i2c_irq_vector_unit
    import i2c_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic              bus_busy_i,
    input  logic              rx_shift_full_i,
    input  logic              rx_data_read_i,
    input  logic              tx_data_write_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] vec_clr;
    logic [CODE_W-1:0]  vec_code;
    logic               rd_vec;
    reg_sel_e           sel;

    assign sel    = reg_sel_e'(reg_addr_i);
    assign rd_vec = reg_rd_i && (sel == SEL_VECTOR);
    assign pend   = flags & enable_q;
    assign irq_o  = |pend;

    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= '0;
        else if (reg_wr_i && sel == SEL_ENABLE)
            enable_q <= reg_wdata_i[NUM_SRC-1:0];
    end

    irq_prio_enc #(.N(NUM_SRC), .CW(CODE_W)) u_enc (
        .pend_i (pend),
        .code_o (vec_code)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_vclr
        if (g == IDX_RXRDY || g == IDX_TXRDY) begin : g_data
            assign vec_clr[g] = 1'b0;
        end else begin : g_ctl
            assign vec_clr[g] = rd_vec && (vec_code == CODE_W'(g + 1));
        end
    end

    always_comb begin
        clr = vec_clr;
        if (reg_wr_i && sel == SEL_STATUS)
            clr = clr | reg_wdata_i[NUM_SRC-1:0];
        clr[IDX_RXRDY] = clr[IDX_RXRDY] | rx_data_read_i;
        clr[IDX_TXRDY] = clr[IDX_TXRDY] | tx_data_write_i;
    end

    irq_flag_bank #(.N(NUM_SRC)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_i),
        .clr_i  (clr),
        .flag_o (flags)
    );

    always_comb begin
        reg_rdata_o = '0;
        unique case (sel)
            SEL_ENABLE: reg_rdata_o[NUM_SRC-1:0] = enable_q;
            SEL_STATUS: begin
                reg_rdata_o[NUM_SRC-1:0] = flags;
                reg_rdata_o[BIT_RSFULL]  = rx_shift_full_i;
                reg_rdata_o[BIT_BBUSY]   = bus_busy_i;
            end
            SEL_VECTOR: reg_rdata_o[CODE_W-1:0] = vec_code;
            SEL_SPARE:  reg_rdata_o = '0;
            default:    reg_rdata_o = '0;
        endcase
    end

    // R7: line and vector agree on whether anything enabled is pending
    p_irq_vs_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (vec_code != '0));
    // R8: a vector read retires a control-event code
    p_vec_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vec && vec_code != 3'd0 && vec_code != 3'd4 && vec_code != 3'd5
         && !evt_i[vec_code - 3'd1]) |=> !flags[$past(vec_code) - 3'd1]);
    // R8: data-ready flags survive a vector read
    p_vec_read_keeps_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vec && vec_code == 3'd4 && !rx_data_read_i
         && !(reg_wr_i && sel == SEL_STATUS)) |=> flags[IDX_RXRDY]);
    // R9: the receive data strobe retires receive-ready
    p_rx_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_data_read_i && !evt_i[IDX_RXRDY]) |=> !flags[IDX_RXRDY]);
    // R9: the transmit data strobe retires transmit-ready
    p_tx_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_data_write_i && !evt_i[IDX_TXRDY]) |=> !flags[IDX_TXRDY]);
endmodule

// File: tb/tb_i2c_irq_vector_unit.sv
module tb_i2c_irq_vector_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  evt;
    logic        bb, rsf, rxrd, txwr;
    logic [1:0]  addr;
    logic        wr, rd;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [6:0] m_flags;
    logic [6:0] m_mask;

    always #5 clk = ~clk;

    i2c_irq_vector_unit dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_busy_i(bb),
        .rx_shift_full_i(rsf), .rx_data_read_i(rxrd), .tx_data_write_i(txwr),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [2:0] m_vec(logic [6:0] f, logic [6:0] m);
        for (int i = 0; i < 7; i++)
            if (f[i] && m[i]) return 3'(i + 1);
        return 3'd0;
    endfunction

    function automatic logic [15:0] m_read(logic [1:0] a);
        logic [15:0] r = '0;
        case (a)
            2'd0: r[6:0] = m_mask;
            2'd1: begin r[6:0] = m_flags; r[11] = rsf; r[12] = bb; end
            2'd2: r[2:0] = m_vec(m_flags, m_mask);
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // One cycle of stimulus; a read is checked before the edge, irq after it.
    task automatic cyc(string tag, logic [6:0] e, logic [1:0] a, logic w, logic r,
                       logic [15:0] d, logic rx, logic tx);
        logic [6:0] clrm;
        logic [2:0] v;
        @(negedge clk);
        evt = e; addr = a; wr = w; rd = r; wdata = d; rxrd = rx; txwr = tx;
        #1;
        if (r) chk(tag, rdata, m_read(a));
        clrm = '0;
        if (w && a == 2'd1) clrm = d[6:0];
        v = m_vec(m_flags, m_mask);
        if (r && a == 2'd2 && v != 0 && v != 4 && v != 5) clrm[v-1] = 1'b1;
        if (rx) clrm[3] = 1'b1;
        if (tx) clrm[4] = 1'b1;
        @(posedge clk);
        m_flags = e | (m_flags & ~clrm);
        if (w && a == 2'd0) m_mask = d[6:0];
        #1;
        chk({tag, " irq R7"}, {15'd0, irq}, {15'd0, |(m_flags & m_mask)});
        evt = '0; wr = 0; rd = 0; rxrd = 0; txwr = 0;
    endtask

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        evt = '0; bb = 0; rsf = 0; rxrd = 0; txwr = 0;
        addr = '0; wr = 0; rd = 0; wdata = '0;
        m_flags = '0; m_mask = '0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        cyc("R1 enable", 0, 2'd0, 0, 1, 0, 0, 0);
        cyc("R1 status", 0, 2'd1, 0, 1, 0, 0, 0);
        cyc("R1 vector", 0, 2'd2, 0, 1, 0, 0, 0);
        // R2 events set flags while masked; live levels
        bb = 1; rsf = 1;
        cyc("R2 set", 7'h55, 2'd1, 0, 0, 0, 0, 0);
        cyc("R2 status", 0, 2'd1, 0, 1, 0, 0, 0);
        bb = 0;
        cyc("R2 live bb", 0, 2'd1, 0, 1, 0, 0, 0);
        // R5 enable register with upper bits written
        cyc("R5 wr", 0, 2'd0, 1, 0, 16'hFFFF, 0, 0);
        cyc("R5 rd", 0, 2'd0, 0, 1, 0, 0, 0);
        // R6 lowest code
        cyc("R6 vec", 0, 2'd2, 0, 1, 0, 0, 0);
        // R3 mixed write-1-clear
        cyc("R3 w1c", 0, 2'd1, 1, 0, 16'h0005, 0, 0);
        cyc("R3 status", 0, 2'd1, 0, 1, 0, 0, 0);
        // R4 pulse vs write-1-clear
        cyc("R4 collide", 7'h10, 2'd1, 1, 0, 16'h0010, 0, 0);
        cyc("R4 status", 0, 2'd1, 0, 1, 0, 0, 0);
        // R8 drain: code 5 stays, vector stuck at 5
        cyc("R8 rd5", 0, 2'd2, 0, 1, 0, 0, 0);
        cyc("R8 rd5 again", 0, 2'd2, 0, 1, 0, 0, 0);
        // R9 tx strobe retires it, then code 7
        cyc("R9 tx", 0, 2'd1, 0, 0, 0, 0, 1);
        cyc("R8 rd7", 0, 2'd2, 0, 1, 0, 0, 0);
        cyc("R8 after", 0, 2'd2, 0, 1, 0, 0, 0);
        // R8 code 4 persists, R9 rx strobe; R4 pulse vs vector read
        cyc("R8 set", 7'h0B, 2'd1, 0, 0, 0, 0, 0);
        cyc("R4 vec collide", 7'h01, 2'd2, 0, 1, 0, 0, 0);
        cyc("R8 rd1", 0, 2'd2, 0, 1, 0, 0, 0);
        cyc("R8 rd2", 0, 2'd2, 0, 1, 0, 0, 0);
        cyc("R8 rd4", 0, 2'd2, 0, 1, 0, 0, 0);
        cyc("R4 rx collide", 7'h08, 2'd1, 0, 0, 0, 1, 0);
        cyc("R9 rx", 0, 2'd1, 0, 1, 0, 1, 0);
        cyc("R9 status", 0, 2'd1, 0, 1, 0, 0, 0);
        // R10 ignored writes and spare address
        cyc("R10 set", 7'h7F, 2'd1, 0, 0, 0, 0, 0);
        cyc("R10 wr vec", 0, 2'd2, 1, 0, 16'hFFFF, 0, 0);
        cyc("R10 wr spare", 0, 2'd3, 1, 0, 16'hFFFF, 0, 0);
        cyc("R10 status", 0, 2'd1, 0, 1, 0, 0, 0);
        cyc("R10 enable", 0, 2'd0, 0, 1, 0, 0, 0);
        cyc("R10 spare", 0, 2'd3, 0, 1, 0, 0, 0);
        // R6 R7 random mix
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            logic [6:0] e;
            logic [1:0] a;
            logic w, r, rx, tx;
            e  = ($urandom % 3 == 0) ? 7'($urandom) : 7'd0;
            a  = 2'($urandom);
            w  = ($urandom % 4 == 0);
            r  = ($urandom % 2 == 0);
            rx = ($urandom % 8 == 0);
            tx = ($urandom % 8 == 0);
            bb = 1'($urandom); rsf = 1'($urandom);
            cyc("R6 rand", e, a, w, r, 16'($urandom), rx, tx);
        end
        finish_up();
    end
endmodule